// File: doc/BRIEF.md
# Gated-Clock Serial PCM Sample Port

This block moves 16-bit two's complement linear PCM samples on two independent serial channels that share one bit clock. The bit clock is gapped: it runs only while a channel's enable strobe is high and may stop completely between frames. Each channel has its own enable strobe, one serial input and one serial output. The block samples incoming bits on the falling edge of the bit clock. It launches outgoing bits on the rising edge. It reports each received sample as a parallel word with a one-cycle valid pulse.

The bit clock, the strobes and the serial inputs are oversampled by a fast system clock through a synchronizer. The block finds the bit clock edges in the system clock domain. The number of falling edges inside a window sets the transfer width: eight clocks carry a byte and sixteen carry a full linear sample. A window that closes after any other count is rejected with an error pulse. Each serial output is driven only while its own strobe is active. The first bit is already on the line before the first falling edge.

Top module: `pcm_strobe_port`

## Requirements
- R1: After reset the serial outputs, output enables, valid, wide and error flags are 0 and both received words read 0.
- R2: A channel's output enable equals its own strobe (after the input synchronizer); while the enable is 0 its serial output reads 0.
- R3: When a strobe rises, bit 15 of that channel's parallel transmit word is on the serial output before the first falling bit-clock edge of the window.
- R4: Inside a window, each rising bit-clock edge that follows at least one falling edge advances the transmit output by one bit, MSB first, so the k-th rising edge presents bit 15-k. Zeros follow bit 0, and an 8-clock window therefore carries bits 15..8.
- R5: Serial input bits are taken on falling bit-clock edges, MSB first. A window with exactly 16 falling edges yields the 16 bits as the received word, with a valid pulse and the wide flag at 1.
- R6: A window with exactly 8 falling edges yields the 8 received bits in word bits 7..0 with bits 15..8 at 0, a valid pulse and the wide flag at 0.
- R7: A window with any other count of falling edges, including 0 and counts well above 16, yields one error pulse and no valid pulse, and the received word keeps its previous value.
- R8: The two channels are independent: a window on one strobe causes no valid pulse, no error pulse and no word change on the other channel.
- R9: Valid and error are each a single-cycle pulse, at most one per window and never high together.
- R10: Bit-clock edges and serial input activity while a channel's strobe is low have no effect on that channel's outputs or on its next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial interface |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Gapped serial bit clock shared by both channels |
| enA | input | 1 | Enable strobe of channel A |
| enB | input | 1 | Enable strobe of channel B |
| rxSerA | input | 1 | Serial data input of channel A |
| rxSerB | input | 1 | Serial data input of channel B |
| txWordA | input | 16 | Parallel word to send on channel A, loaded at strobe rise |
| txWordB | input | 16 | Parallel word to send on channel B, loaded at strobe rise |
| txSerA | output | 1 | Serial data output of channel A |
| txSerB | output | 1 | Serial data output of channel B |
| txOeA | output | 1 | Output enable of txSerA (0 means high impedance) |
| txOeB | output | 1 | Output enable of txSerB (0 means high impedance) |
| rxWordA | output | 16 | Last accepted received word of channel A |
| rxWordB | output | 16 | Last accepted received word of channel B |
| rxValidA | output | 1 | One-cycle pulse: rxWordA updated |
| rxValidB | output | 1 | One-cycle pulse: rxWordB updated |
| rxWideA | output | 1 | 1 if the last accepted channel A word was 16 bits |
| rxWideB | output | 1 | 1 if the last accepted channel B word was 16 bits |
| rxErrA | output | 1 | One-cycle pulse: channel A window had an illegal clock count |
| rxErrB | output | 1 | One-cycle pulse: channel B window had an illegal clock count |

## Verification
The bench sweeps the clock count per window from 0 to 20 and adds a 40-clock window. This catches a counter that wraps back to a legal value, or one that accepts 7, 9, 15 or 17 clocks as a legal width. At every bit it checks the serial output during the high phase. A design that shifts on the very first rising edge of an idle-low clock, or that presents the first bit late, therefore loses the MSB. Byte windows check the placement and zero-fill of the received byte and the wide flag. Bursts of clock and data while the strobes are low, and windows on only one channel, expose a design that captures outside its window or lets one channel disturb the other.

// File: rtl/pcm_strobe_port_pkg.sv
package pcm_strobe_port_pkg;

  // Strobes from a lane controller to its datapath, one cycle each.
  typedef struct packed {
    logic load;      // strobe just rose: load tx word, clear rx shifter
    logic shiftIn;   // falling bit-clock edge inside the window
    logic shiftOut;  // rising bit-clock edge after the first capture
    logic done8;     // window closed after exactly a half word
    logic done16;    // window closed after exactly a full word
  } laneStrobe_t;

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pcm_lane_ctrl.sv
module pcm_lane_ctrl
  import pcm_strobe_port_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enSync,
  input  logic        bitRise,
  input  logic        bitFall,
  output laneStrobe_t strb,
  output logic        errPulse
);

  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             enPrev;
  logic             enRise;
  logic             enFall;
  logic [CNT_W-1:0] bitCount;
  logic             isHalf;
  logic             isFull;

  assign enRise = enSync & ~enPrev;
  assign enFall = ~enSync & enPrev;
  assign isHalf = (bitCount == CNT_W'(HALF_W));
  assign isFull = (bitCount == CNT_W'(WORD_W));

  always_comb begin
    strb.load     = enRise;
    strb.shiftIn  = enSync & ~enRise & bitFall;
    strb.shiftOut = enSync & ~enRise & bitRise & (bitCount != '0);
    strb.done8    = enFall & isHalf;
    strb.done16   = enFall & isFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev   <= 1'b0;
      bitCount <= '0;
      errPulse <= 1'b0;
    end else begin
      enPrev   <= enSync;
      errPulse <= enFall & ~isHalf & ~isFull;
      if (enRise) bitCount <= '0;
      else if (strb.shiftIn && bitCount != CNT_MAX) bitCount <= bitCount + 1'b1;
    end
  end

endmodule

// File: rtl/pcm_lane_data.sv
module pcm_lane_data
  import pcm_strobe_port_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strb,
  input  logic              serIn,
  input  logic [WORD_W-1:0] txWord,
  output logic              serOut,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              rxWide
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;

  assign serOut = txShift[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
      rxWide  <= 1'b0;
    end else begin
      rxValid <= strb.done8 | strb.done16;
      if (strb.load) begin
        txShift <= txWord;
        rxShift <= '0;
      end else begin
        if (strb.shiftOut) txShift <= {txShift[WORD_W-2:0], 1'b0};
        if (strb.shiftIn)  rxShift <= {rxShift[WORD_W-2:0], serIn};
      end
      if (strb.done16) begin
        rxWord <= rxShift;
        rxWide <= 1'b1;
      end else if (strb.done8) begin
        rxWord <= {{(WORD_W-HALF_W){1'b0}}, rxShift[HALF_W-1:0]};
        rxWide <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_strobe_port_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              enA,
  input  logic              enB,
  input  logic              rxSerA,
  input  logic              rxSerB,
  input  logic [WORD_W-1:0] txWordA,
  input  logic [WORD_W-1:0] txWordB,
  output logic              txSerA,
  output logic              txSerB,
  output logic              txOeA,
  output logic              txOeB,
  output logic [WORD_W-1:0] rxWordA,
  output logic [WORD_W-1:0] rxWordB,
  output logic              rxValidA,
  output logic              rxValidB,
  output logic              rxWideA,
  output logic              rxWideB,
  output logic              rxErrA,
  output logic              rxErrB
);

  localparam int LANES  = 2;
  localparam int SYNC_W = 1 + 2 * LANES;

  logic [SYNC_W-1:0] syncVec;
  logic              bitClkS;
  logic              bitClkPrev;
  logic              bitRise;
  logic              bitFall;
  logic [LANES-1:0]  enS;
  logic [LANES-1:0]  serS;

  logic [WORD_W-1:0] txWordL [LANES];
  logic [WORD_W-1:0] rxWordL [LANES];
  logic [LANES-1:0]  serOutL;
  logic [LANES-1:0]  validL;
  logic [LANES-1:0]  wideL;
  logic [LANES-1:0]  errL;

  pcm_in_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({bitClk, enB, enA, rxSerB, rxSerA}),
    .syncOut(syncVec)
  );

  assign bitClkS = syncVec[SYNC_W-1];
  assign enS     = syncVec[2*LANES-1:LANES];
  assign serS    = syncVec[LANES-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) bitClkPrev <= 1'b0;
    else       bitClkPrev <= bitClkS;
  end

  assign bitRise = bitClkS & ~bitClkPrev;
  assign bitFall = ~bitClkS & bitClkPrev;

  assign txWordL[0] = txWordA;
  assign txWordL[1] = txWordB;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      laneStrobe_t strb;

      pcm_lane_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk     (clk),
        .rstN    (rstN),
        .enSync  (enS[g]),
        .bitRise (bitRise),
        .bitFall (bitFall),
        .strb    (strb),
        .errPulse(errL[g])
      );

      pcm_lane_data #(.WORD_W(WORD_W)) u_data (
        .clk    (clk),
        .rstN   (rstN),
        .strb   (strb),
        .serIn  (serS[g]),
        .txWord (txWordL[g]),
        .serOut (serOutL[g]),
        .rxWord (rxWordL[g]),
        .rxValid(validL[g]),
        .rxWide (wideL[g])
      );
    end
  endgenerate

  assign txOeA    = enS[0];
  assign txOeB    = enS[1];
  assign txSerA   = enS[0] & serOutL[0];
  assign txSerB   = enS[1] & serOutL[1];
  assign rxWordA  = rxWordL[0];
  assign rxWordB  = rxWordL[1];
  assign rxValidA = validL[0];
  assign rxValidB = validL[1];
  assign rxWideA  = wideL[0];
  assign rxWideB  = wideL[1];
  assign rxErrA   = errL[0];
  assign rxErrB   = errL[1];

endmodule

// File: rtl/pcm_strobe_port_checker.sv
module pcm_strobe_port_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              txSerA,
  input logic              txSerB,
  input logic              txOeA,
  input logic              txOeB,
  input logic [WORD_W-1:0] rxWordA,
  input logic [WORD_W-1:0] rxWordB,
  input logic              rxValidA,
  input logic              rxValidB,
  input logic              rxErrA,
  input logic              rxErrB
);

  AST_IDLE_LOW_A: assert property (@(posedge clk) disable iff (!rstN) !txOeA |-> !txSerA); // R2
  AST_IDLE_LOW_B: assert property (@(posedge clk) disable iff (!rstN) !txOeB |-> !txSerB); // R2
  AST_VALID_ERR_EXCL_A: assert property (@(posedge clk) disable iff (!rstN) !(rxValidA && rxErrA)); // R9
  AST_VALID_ERR_EXCL_B: assert property (@(posedge clk) disable iff (!rstN) !(rxValidB && rxErrB)); // R9
  AST_VALID_PULSE_A: assert property (@(posedge clk) disable iff (!rstN) rxValidA |=> !rxValidA); // R9
  AST_ERR_PULSE_A: assert property (@(posedge clk) disable iff (!rstN) rxErrA |=> !rxErrA); // R9
  AST_WORD_HOLD_A: assert property (@(posedge clk) disable iff (!rstN) !rxValidA |-> $stable(rxWordA)); // R7
  AST_WORD_HOLD_B: assert property (@(posedge clk) disable iff (!rstN) !rxValidB |-> $stable(rxWordB)); // R8

endmodule

bind pcm_strobe_port pcm_strobe_port_checker #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/pcm_strobe_port_bench.sv
module pcm_strobe_port_bench;

  localparam int HALF = 8;  // system clocks per bit-clock phase

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        enA = 1'b0, enB = 1'b0;
  logic        rxSerA = 1'b0, rxSerB = 1'b0;
  logic [15:0] txWordA = '0, txWordB = '0;
  logic        txSerA, txSerB, txOeA, txOeB;
  logic [15:0] rxWordA, rxWordB;
  logic        rxValidA, rxValidB, rxWideA, rxWideB, rxErrA, rxErrB;

  int errors = 0;
  int checks = 0;
  logic [15:0] expWordA = '0, expWordB = '0;
  logic        expWideA = 1'b0, expWideB = 1'b0;

  always #2.5 clk = ~clk;

  pcm_strobe_port u_pcm_strobe_port (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .enA(enA), .enB(enB),
    .rxSerA(rxSerA), .rxSerB(rxSerB), .txWordA(txWordA), .txWordB(txWordB),
    .txSerA(txSerA), .txSerB(txSerB), .txOeA(txOeA), .txOeB(txOeB),
    .rxWordA(rxWordA), .rxWordB(rxWordB), .rxValidA(rxValidA), .rxValidB(rxValidB),
    .rxWideA(rxWideA), .rxWideB(rxWideB), .rxErrA(rxErrA), .rxErrB(rxErrB)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Run one window of n bit clocks; useA/useB select which strobes open.
  task automatic runWindow(input bit useA, input bit useB, input int n,
                           input logic [15:0] tA, input logic [15:0] tB,
                           input logic [15:0] rA, input logic [15:0] rB);
    int vA = 0, vB = 0, eA = 0, eB = 0;
    logic [15:0] oldB = rxWordB;
    txWordA = tA;
    txWordB = tB;
    enA = useA;
    enB = useB;
    tick(HALF);
    chk("R2 oeA", txOeA, useA);
    chk("R2 oeB", txOeB, useB);
    for (int i = 0; i < n; i++) begin
      bitClk = 1'b1;
      rxSerA = (i < 16) ? rA[15-i] : 1'b0;
      rxSerB = (i < 16) ? rB[15-i] : 1'b0;
      tick(HALF);
      if (useA) chk((i == 0) ? "R3 first bit A" : "R4 shift A", txSerA, (i < 16) ? tA[15-i] : 1'b0);
      if (useB) chk((i == 0) ? "R3 first bit B" : "R4 shift B", txSerB, (i < 16) ? tB[15-i] : 1'b0);
      if (!useB) chk("R2 idle B low", txSerB, 0);
      bitClk = 1'b0;
      tick(HALF);
    end
    enA = 1'b0;
    enB = 1'b0;
    for (int c = 0; c < 12; c++) begin
      tick(1);
      vA += rxValidA; vB += rxValidB; eA += rxErrA; eB += rxErrB;
    end
    if (useA) begin
      if (n == 16) begin expWordA = rA; expWideA = 1'b1; end
      if (n == 8)  begin expWordA = {8'h00, rA[15:8]}; expWideA = 1'b0; end
      chk((n == 16) ? "R5 validA" : (n == 8) ? "R6 validA" : "R7 no validA", vA, (n == 8 || n == 16));
      chk("R7 errA", eA, !(n == 8 || n == 16));
      chk((n == 16) ? "R5 wordA" : (n == 8) ? "R6 wordA" : "R7 wordA held", rxWordA, expWordA);
      chk((n == 8) ? "R6 wideA" : "R5 wideA", rxWideA, expWideA);
    end
    if (useB) begin
      if (n == 16) begin expWordB = rB; expWideB = 1'b1; end
      if (n == 8)  begin expWordB = {8'h00, rB[15:8]}; expWideB = 1'b0; end
      chk("R9 validB count", vB, (n == 8 || n == 16));
      chk("R9 errB count", eB, !(n == 8 || n == 16));
      chk("R5 wordB", rxWordB, expWordB);
      chk("R6 wideB", rxWideB, expWideB);
    end else begin
      chk("R8 no validB", vB, 0);
      chk("R8 no errB", eB, 0);
      chk("R8 wordB unchanged", rxWordB, oldB);
    end
    chk("R2 oeA idle", txOeA, 0);
    tick(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);
    chk("R1 txSerA", txSerA, 0);
    chk("R1 oe", {txOeA, txOeB}, 0);
    chk("R1 flags", {rxValidA, rxValidB, rxWideA, rxWideB, rxErrA, rxErrB}, 0);
    chk("R1 words", {rxWordA, rxWordB}, 0);

    // Count sweep, including a long window that must not wrap to a legal count.
    for (int n = 0; n <= 21; n++) begin
      int cnt = (n == 21) ? 40 : n;
      runWindow(1'b1, (n % 2) == 0, cnt,
                16'hA5C3 ^ 16'(n * 16'h1357), 16'h5A3C ^ 16'(n * 16'h0B71),
                16'h3C5A + 16'(n * 16'h0F1D), 16'hC3A5 + 16'(n * 16'h2E4B));
    end

    // Data patterns on both widths, with channel B alone as well.
    for (int p = 0; p < 6; p++) begin
      logic [15:0] pat = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : (p == 2) ? 16'h8000 :
                         (p == 3) ? 16'h0001 : (p == 4) ? 16'h7FFE : 16'h8181;
      runWindow(1'b1, 1'b1, 16, pat, ~pat, ~pat, pat);
      runWindow(1'b1, 1'b0, 8, ~pat, pat, pat, ~pat);
      runWindow(1'b0, 1'b1, 8, pat, pat, pat ^ 16'h1234, pat ^ 16'h4321);
      chk("R8 wordA untouched by B window", rxWordA, expWordA);
    end

    // Clock and data activity with both strobes low must do nothing.
    for (int i = 0; i < 12; i++) begin
      bitClk = ~bitClk;
      rxSerA = i[0];
      rxSerB = ~i[0];
      tick(HALF);
      chk("R10 outputs idle", {txSerA, txSerB, txOeA, txOeB, rxValidA, rxValidB, rxErrA, rxErrB}, 0);
    end
    bitClk = 1'b0;
    tick(HALF);
    chk("R10 wordA held", rxWordA, expWordA);
    chk("R10 wordB held", rxWordB, expWordB);
    runWindow(1'b1, 1'b1, 16, 16'hBEEF, 16'h1357, 16'hCAFE, 16'hF00D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule